// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block decides the outcome of a conditional branch that applies to a whole vector of condition bits rather than to a single one. A one-cycle start pulse captures the following inputs:

- a condition-bit vector and a per-element predicate mask;
- the current vector length and the maximum vector length;
- four mode bits:
  - `mode_all` picks AND or OR reduction;
  - `mode_vlset` allows the vector length to be shortened;
  - `mode_incl` decides whether the deciding element counts in the shortened length;
  - `mode_lr_cond` makes the link-register write depend on the outcome.

After the start pulse the block examines one element per clock, from index 0 upward. Elements whose predicate bit is clear are skipped. The scan stops at the first element that settles the result. In OR mode that is the first passing element. In AND mode it is the first failing element.

When the scan ends, the block raises a single-cycle `done` pulse. It then holds four outputs until the next accepted start: the taken flag, a proposed new vector length, a vector-length write enable and a link-register write enable. The surrounding branch unit uses these outputs to redirect fetch and to update its vector-length and link registers. The maximum vector length is only read: it bounds the scan and is never rewritten.

Top module: `vbr_eval`

## Requirements
- R1: A `start` pulse seen while idle latches all inputs. Element k is examined on the (k+1)-th rising edge after the edge that took `start`. `done` is high for exactly one cycle, right after the edge that settles the result. If no element decides, that is the edge after the last element, which is edge L+1 for an effective length L.
- R2: When `mode_all`=0 (OR mode), the first unmasked element whose condition bit is 1 ends the scan with `taken`=1. If the scan finishes without such an element, `taken`=0.
- R3: When `mode_all`=1 (AND mode), the first unmasked element whose condition bit is 0 ends the scan with `taken`=0. If the scan finishes with at least one unmasked element tested and none failing, `taken`=1.
- R4: With `mode_vlset`=1 and `mode_incl`=0, a deciding element at index k gives `new_vl`=k and `vl_we`=1.
- R5: With `mode_vlset`=1 and `mode_incl`=1, a deciding element at index k gives `new_vl`=k+1 and `vl_we`=1.
- R6: If no element decides, or `mode_vlset`=0, then `vl_we`=0 and `new_vl` equals the effective length.
- R7: An element whose predicate bit is 0 is skipped, and its condition bit has no effect on the result.
- R8: If every element within the effective length is masked, or the effective length is 0, then `taken`=0.
- R9: With `mode_lr_cond`=1, `lr_we` equals `taken`. With `mode_lr_cond`=0, `lr_we`=1 after every scan.
- R10: `taken`, `new_vl`, `vl_we` and `lr_we` stay constant from the `done` pulse until the next accepted start. A `start` that arrives while a scan is running is ignored.
- R11: The effective length is the smallest of `vl_in`, `mvl_in` and 64. Elements at or beyond it are never examined. The block has no output that writes the maximum length.
- R12: After reset, `busy`, `done`, `taken`, `new_vl`, `vl_we` and `lr_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan; honoured only while idle |
| cond_vec | input | 64 | Condition bit per element |
| pred_vec | input | 64 | Predicate mask; 0 skips the element |
| vl_in | input | 7 | Current vector length |
| mvl_in | input | 7 | Maximum vector length (read only) |
| mode_all | input | 1 | 1: AND reduction, 0: OR reduction |
| mode_vlset | input | 1 | Allow vector-length truncation |
| mode_incl | input | 1 | Include the deciding element in the new length |
| mode_lr_cond | input | 1 | Link write only when taken |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch outcome |
| new_vl | output | 7 | Proposed vector length |
| vl_we | output | 1 | Vector-length write enable |
| lr_we | output | 1 | Link-register write enable |

## Verification
The assertions assume a few things about how the block is driven:
- `start` is honoured only while `busy` is low.
- Vector and mode inputs matter only on the edge that accepts `start`.
- Lengths may exceed 64 or the maximum length and are clamped rather than treated as an error.

The stimulus drives every input on the falling clock edge. It raises `start` only while the block is idle, except in one deliberate case: a start issued mid-scan with different inputs, to show that it is ignored. After the `done` pulse the stimulus changes the vector and mode inputs, to confirm that the held results do not follow them.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
    localparam int unsigned VBR_MAX_EL = 64;
    localparam int unsigned VBR_LEN_W  = $clog2(VBR_MAX_EL) + 1;

    typedef struct packed {
        logic                  busy;
        logic                  done;
        logic [VBR_LEN_W-1:0]  idx;
        logic [VBR_LEN_W-1:0]  len;
        logic [VBR_MAX_EL-1:0] cond;
        logic [VBR_MAX_EL-1:0] pred;
        logic                  all;
        logic                  vlset;
        logic                  incl;
        logic                  lrc;
        logic                  any_tested;
        logic                  taken;
        logic [VBR_LEN_W-1:0]  new_vl;
        logic                  vl_we;
        logic                  lr_we;
    } vbr_state_t;
endpackage

// File: rtl/vbr_elem_pick.sv
module vbr_elem_pick #(
    parameter int unsigned N_EL  = 64,
    parameter int unsigned LEN_W = 7
) (
    input  logic [N_EL-1:0]  cond_vec,
    input  logic [N_EL-1:0]  pred_vec,
    input  logic [LEN_W-1:0] idx,
    input  logic [LEN_W-1:0] len,
    output logic             in_range,
    output logic             el_cond,
    output logic             el_pred
);
    localparam int unsigned IDX_W = $clog2(N_EL);

    logic [IDX_W-1:0] sel;

    always_comb begin
        sel      = idx[IDX_W-1:0];
        in_range = (idx < len);
        el_cond  = in_range & cond_vec[sel];
        el_pred  = in_range & pred_vec[sel];
    end
endmodule

// File: rtl/vbr_decide.sv
module vbr_decide (
    input  logic el_active,
    input  logic el_cond,
    input  logic mode_all,
    output logic decides,
    output logic outcome
);
    // OR mode settles on a pass, AND mode settles on a fail.
    always_comb begin
        decides = el_active & (mode_all ? ~el_cond : el_cond);
        outcome = el_cond;
    end
endmodule

// File: rtl/vbr_eval.sv
module vbr_eval
    import vbr_pkg::*;
#(
    parameter int unsigned N_EL  = VBR_MAX_EL,
    parameter int unsigned LEN_W = VBR_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N_EL-1:0]  cond_vec,
    input  logic [N_EL-1:0]  pred_vec,
    input  logic [LEN_W-1:0] vl_in,
    input  logic [LEN_W-1:0] mvl_in,
    input  logic             mode_all,
    input  logic             mode_vlset,
    input  logic             mode_incl,
    input  logic             mode_lr_cond,
    output logic             busy,
    output logic             done,
    output logic             taken,
    output logic [LEN_W-1:0] new_vl,
    output logic             vl_we,
    output logic             lr_we
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(N_EL);

    vbr_state_t s_d, s_q;

    logic in_range, el_cond, el_pred, decides, outcome;
    logic [LEN_W-1:0] eff_len;

    vbr_elem_pick #(.N_EL(N_EL), .LEN_W(LEN_W)) u_pick (
        .cond_vec (s_q.cond),
        .pred_vec (s_q.pred),
        .idx      (s_q.idx),
        .len      (s_q.len),
        .in_range (in_range),
        .el_cond  (el_cond),
        .el_pred  (el_pred)
    );

    vbr_decide u_decide (
        .el_active (el_pred),
        .el_cond   (el_cond),
        .mode_all  (s_q.all),
        .decides   (decides),
        .outcome   (outcome)
    );

    always_comb begin
        eff_len = vl_in;
        if (mvl_in < eff_len)  eff_len = mvl_in;
        if (MAX_LEN < eff_len) eff_len = MAX_LEN;
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy       = 1'b1;
                s_d.idx        = '0;
                s_d.len        = eff_len;
                s_d.cond       = cond_vec;
                s_d.pred       = pred_vec;
                s_d.all        = mode_all;
                s_d.vlset      = mode_vlset;
                s_d.incl       = mode_incl;
                s_d.lrc        = mode_lr_cond;
                s_d.any_tested = 1'b0;
                s_d.taken      = 1'b0;
                s_d.new_vl     = '0;
                s_d.vl_we      = 1'b0;
                s_d.lr_we      = 1'b0;
            end
        end else if (!in_range) begin
            // Scan exhausted without a deciding element.
            s_d.busy   = 1'b0;
            s_d.done   = 1'b1;
            s_d.taken  = s_q.all & s_q.any_tested;
            s_d.new_vl = s_q.len;
            s_d.vl_we  = 1'b0;
            s_d.lr_we  = s_q.lrc ? (s_q.all & s_q.any_tested) : 1'b1;
        end else if (decides) begin
            s_d.busy   = 1'b0;
            s_d.done   = 1'b1;
            s_d.taken  = outcome;
            s_d.vl_we  = s_q.vlset;
            if (!s_q.vlset)     s_d.new_vl = s_q.len;
            else if (s_q.incl)  s_d.new_vl = s_q.idx + 1'b1;
            else                s_d.new_vl = s_q.idx;
            s_d.lr_we  = s_q.lrc ? outcome : 1'b1;
        end else begin
            s_d.any_tested = s_q.any_tested | el_pred;
            s_d.idx        = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy   = s_q.busy;
    assign done   = s_q.done;
    assign taken  = s_q.taken;
    assign new_vl = s_q.new_vl;
    assign vl_we  = s_q.vl_we;
    assign lr_we  = s_q.lr_we;

    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_vl_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vl_we) |-> (new_vl <= s_q.len));

    p_no_vlwe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !s_q.vlset) |-> (!vl_we && new_vl == s_q.len));

    p_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_range && !el_pred) |=> !done);

    p_lr_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.lrc) |-> (lr_we == taken));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> $stable({taken, new_vl, vl_we, lr_we}));

    p_len_clamp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (s_q.len <= MAX_LEN && s_q.idx <= s_q.len));
endmodule

// File: tb/test_vbr_eval.sv
module test_vbr_eval;
    localparam int unsigned CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] cond;
        logic [63:0] pred;
        logic [6:0]  vl;
        logic [6:0]  mvl;
        logic        all;
        logic        vlset;
        logic        incl;
        logic        lrc;
        logic        e_taken;
        logic [6:0]  e_vl;
        logic        e_vlwe;
        logic        e_lrwe;
        logic [7:0]  e_lat;
    } vec_t;

    localparam logic [63:0] ONES = {64{1'b1}};
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{64'h4,  ONES, 7'd8,  7'd64, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 7'd2,  1'b1, 1'b1, 8'd3},
        '{64'h4,  ONES, 7'd8,  7'd64, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 7'd3,  1'b1, 1'b1, 8'd3},
        '{64'hFB, ONES, 7'd8,  7'd64, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 7'd2,  1'b1, 1'b0, 8'd3},
        '{64'hFF, ONES, 7'd8,  7'd64, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 7'd8,  1'b0, 1'b1, 8'd9},
        '{64'h0,  ONES, 7'd5,  7'd64, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd5,  1'b0, 1'b1, 8'd6},
        '{64'h9,  64'hE, 7'd8, 7'd64, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 7'd4,  1'b1, 1'b1, 8'd4},
        '{64'h0,  64'h0, 7'd6, 7'd64, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 7'd6,  1'b0, 1'b0, 8'd7},
        '{ONES,   ONES, 7'd0,  7'd64, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  1'b0, 1'b1, 8'd1},
        '{64'h400, ONES, 7'd20, 7'd8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7'd8,  1'b0, 1'b0, 8'd9},
        '{64'hFE, ONES, 7'd4,  7'd64, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7'd4,  1'b0, 1'b1, 8'd1},
        '{64'h8000_0000_0000_0000, ONES, 7'd64, 7'd64, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 7'd64, 1'b1, 1'b1, 8'd64},
        '{64'h5,  64'hD, 7'd3, 7'd64, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 7'd3,  1'b0, 1'b1, 8'd4}
    };

    // Requirement tag per table row.
    localparam string TAGS [NV] = '{"R2 R4", "R5", "R3 R4", "R3 R6", "R2 R6 R9",
        "R7 R5", "R8", "R8", "R11", "R6 R9", "R5 R11", "R7 R3"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] cond_vec = '0, pred_vec = '0;
    logic [6:0]  vl_in = '0, mvl_in = '0;
    logic        mode_all = 1'b0, mode_vlset = 1'b0, mode_incl = 1'b0, mode_lr_cond = 1'b0;
    logic        busy, done, taken, vl_we, lr_we;
    logic [6:0]  new_vl;

    int n_checks = 0;
    int n_fail = 0;
    int lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbr_eval i_vbr_eval (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cond_vec(cond_vec), .pred_vec(pred_vec),
        .vl_in(vl_in), .mvl_in(mvl_in),
        .mode_all(mode_all), .mode_vlset(mode_vlset),
        .mode_incl(mode_incl), .mode_lr_cond(mode_lr_cond),
        .busy(busy), .done(done), .taken(taken),
        .new_vl(new_vl), .vl_we(vl_we), .lr_we(lr_we)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cond_vec = v.cond; pred_vec = v.pred; vl_in = v.vl; mvl_in = v.mvl;
        mode_all = v.all; mode_vlset = v.vlset; mode_incl = v.incl; mode_lr_cond = v.lrc;
    endtask

    // Pulse start on a falling edge, then count edges until done is seen.
    task automatic run(input vec_t v, output int edges);
        int cnt;
        apply(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        edges = cnt - 1;
    endtask

    task automatic check_result(input string tag, input vec_t v);
        check(tag, "taken", int'(taken), int'(v.e_taken));
        check(tag, "new_vl", int'(new_vl), int'(v.e_vl));
        check(tag, "vl_we", int'(vl_we), int'(v.e_vlwe));
        check(tag, "lr_we", int'(lr_we), int'(v.e_lrwe));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "busy", int'(busy), 0);
        check("R12", "done", int'(done), 0);
        check("R12", "taken", int'(taken), 0);
        check("R12", "new_vl", int'(new_vl), 0);
        check("R12", "vl_we", int'(vl_we), 0);
        check("R12", "lr_we", int'(lr_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i], lat);
            check({TAGS[i], " R1"}, "latency", lat, int'(VECS[i].e_lat));
            check_result(TAGS[i], VECS[i]);
            @(negedge clk);
            check("R1", "done width", int'(done), 0);
            @(negedge clk);
        end

        // R10: results hold after done while inputs change.
        run(VECS[0], lat);
        apply(VECS[6]);
        repeat (5) @(negedge clk);
        check_result("R10 hold", VECS[0]);

        // R10: start during a scan is ignored.
        apply(VECS[3]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        apply(VECS[0]);
        repeat (2) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check_result("R10 busy start", VECS[3]);
        @(negedge clk);
        check("R10", "busy after", int'(busy), 0);

        // R7: masked failing elements do not alter the AND result.
        run('{64'h0, 64'h0 | 64'h10, 7'd8, 7'd64, 1'b1, 1'b1, 1'b1, 1'b0,
              1'b0, 7'd5, 1'b1, 1'b1, 8'd5}, lat);
        check("R7", "latency", lat, 5);
        check("R7", "new_vl", int'(new_vl), 5);
        check("R7", "taken", int'(taken), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule